// File: doc/BRIEF.md
# Serial Memory Status Register and Write Guard

This block keeps the status byte of a 32K x 8 serial nonvolatile memory and decides, cycle by cycle, whether a status write or an array write may proceed. It sits behind the command decoder of the serial front end. Each command arrives as a one-cycle strobe, with the write data byte and the target byte address presented alongside it. The block also receives the level of the write-protect pin and a busy flag from the programming sequencer.

Three mechanisms together settle whether a write is allowed. The first is a write-enable latch that the host arms and disarms. The second is a two-bit block-protect field that marks the upper part of the address space read-only, in quarter, half or whole-array steps. The third is a hardware lock that freezes the status register while a protect-enable bit is set and the pin is held low. An identification-page select routes the next access to a separate page. A matching lock bit makes that page read-only for good, and one write may not set the select and the lock together. Nonvolatile bits are plain registers that clear on reset.

Top module: `nvm_status_guard`

## Requirements
- R1: `status_o` is {protect-enable, id-select, 0, id-lock, BP1, BP0, write-latch, busy}, bit 7 down to bit 0. Bit 5 always reads 0, and every bit reads 0 after reset while `busy_i` is low.
- R2: Status bit 0 equals `busy_i` in every cycle, whatever data a status write carries.
- R3: With `busy_i` low, `cmd_wren_i` sets the write latch (bit 1) at the next edge and `cmd_wrdi_i` clears it. If both arrive together, clear wins. Reset clears the latch.
- R4: With id-select 0, BP1:BP0 give the protected array range: 00 none, 01 0x6000-0x7FFF, 10 0x4000-0x7FFF, 11 0x0000-0x7FFF. `arr_wr_ok_o` is 0 for an address in that range, whatever the latch, protect-enable or pin.
- R5: With id-select 0 and the address outside the protected range, `arr_wr_ok_o` = latch AND NOT `busy_i`, independent of `wp_pin_i` and protect-enable.
- R6: `stat_wr_ok_o` = latch AND NOT `busy_i` AND NOT (protect-enable AND `wp_pin_i` low).
- R7: A `cmd_stat_wr_i` while `stat_wr_ok_o` is 1 loads protect-enable from `wdata_i[7]` and BP1:BP0 from `wdata_i[3:2]`. It leaves bits 5, 1 and 0 unaffected. With `stat_wr_ok_o` at 0 the command changes nothing.
- R8: An accepted status write with `wdata_i[6]` and `wdata_i[4]` both 1 leaves id-select and id-lock unchanged, while the other fields still load. Otherwise id-select loads `wdata_i[6]` and id-lock is ORed with `wdata_i[4]`.
- R9: Once id-lock is 1 it stays 1 until reset. With id-select 1, `arr_wr_ok_o` = latch AND NOT id-lock AND NOT `busy_i`, and block protection does not apply.
- R10: `id_sel_o` equals status bit 6. A pulse on `arr_done_i` clears id-select at the next edge, unless an accepted status write in the same cycle reloads it.
- R11: An accepted status write, or a `cmd_arr_wr_i` while `arr_wr_ok_o` is 1, marks a write pending. The first cycle in which `busy_i` is low after being high clears the write latch and the pending mark. A command in that same cycle is then applied over the clear.
- R12: While `busy_i` is 1, the write-enable, write-disable, status-write and array-write commands have no effect on any status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wren_i | input | 1 | Write-enable command strobe |
| cmd_wrdi_i | input | 1 | Write-disable command strobe |
| cmd_stat_wr_i | input | 1 | Status-write command strobe |
| cmd_arr_wr_i | input | 1 | Array-write command strobe |
| wdata_i | input | 8 | Data byte of a status write |
| addr_i | input | 15 | Target byte address of an array write |
| wp_pin_i | input | 1 | Write-protect pin level (low = protect) |
| busy_i | input | 1 | Internal write cycle in progress |
| arr_done_i | input | 1 | Pulse: an array read or write has completed |
| status_o | output | 8 | Status byte as read back |
| stat_wr_ok_o | output | 1 | A status write would be accepted this cycle |
| arr_wr_ok_o | output | 1 | An array write to `addr_i` would be accepted this cycle |
| id_sel_o | output | 1 | Route accesses to the identification page |

## Verification
The assertions assume that the command strobes are pulses the decoder has already qualified. They also assume that `busy_i` rises only after a write has been accepted, and that `arr_done_i` arrives as a single-cycle pulse. The random stimulus issues at most one command per cycle. It raises busy only for two to five cycles after an accepted write, and pulses the completion input only in idle cycles. Data bytes are drawn so that the id-lock bit is rarely requested, which keeps the identification page reachable for most of each run. Directed sequences cover the combined select-and-lock write, commands issued during busy, the hardware lock and the permanent page lock.

// File: rtl/nvm_sr_pkg.sv
package nvm_sr_pkg;

    localparam int unsigned SR_W = 8;

    // status byte bit positions (read-back layout)
    localparam int unsigned B_PEN  = 7;
    localparam int unsigned B_ISEL = 6;
    localparam int unsigned B_PAD  = 5;
    localparam int unsigned B_ILCK = 4;
    localparam int unsigned B_BPH  = 3;
    localparam int unsigned B_BPL  = 2;
    localparam int unsigned B_WEL  = 1;
    localparam int unsigned B_RDY  = 0;

    typedef enum logic [1:0] {
        PROT_NONE    = 2'b00,
        PROT_QUARTER = 2'b01,
        PROT_HALF    = 2'b10,
        PROT_ALL     = 2'b11
    } prot_sel_e;

    typedef struct packed {
        logic      pen;     // protect-enable for the pin
        logic      isel;    // identification page select
        logic      ilck;    // identification page lock
        prot_sel_e bp;      // block-protect field
        logic      wel;     // write-enable latch
        logic      pend;    // accepted write awaiting completion
        logic      busy_q;  // busy sampled last cycle
    } sr_state_t;

    localparam sr_state_t SR_RESET = '{
        pen: 1'b0, isel: 1'b0, ilck: 1'b0, bp: PROT_NONE,
        wel: 1'b0, pend: 1'b0, busy_q: 1'b0
    };

endpackage

// File: rtl/nvm_bp_decode.sv
module nvm_bp_decode
    import nvm_sr_pkg::*;
#(
    parameter int unsigned ADDR_W = 15
) (
    input  prot_sel_e         bp_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o
);

    localparam int unsigned MSB = ADDR_W - 1;
    localparam int unsigned NSB = ADDR_W - 2;

    // upper quarter: two top bits set; upper half: top bit set
    logic in_top_quarter;
    logic in_top_half;

    assign in_top_quarter = addr_i[MSB] & addr_i[NSB];
    assign in_top_half    = addr_i[MSB];

    always_comb begin
        unique case (bp_i)
            PROT_NONE:    hit_o = 1'b0;
            PROT_QUARTER: hit_o = in_top_quarter;
            PROT_HALF:    hit_o = in_top_half;
            PROT_ALL:     hit_o = 1'b1;
            default:      hit_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/nvm_wr_gate.sv
module nvm_wr_gate (
    input  logic wel_i,
    input  logic pen_i,
    input  logic isel_i,
    input  logic ilck_i,
    input  logic range_hit_i,
    input  logic wp_pin_i,
    input  logic busy_i,
    output logic stat_ok_o,
    output logic arr_ok_o
);

    logic hw_lock;
    logic armed;
    logic target_open;

    assign hw_lock     = pen_i & ~wp_pin_i;
    assign armed       = wel_i & ~busy_i;
    // identification page answers only to its lock; main array to the range
    assign target_open = isel_i ? ~ilck_i : ~range_hit_i;

    assign stat_ok_o = armed & ~hw_lock;
    assign arr_ok_o  = armed & target_open;

endmodule

// File: rtl/nvm_status_guard.sv
module nvm_status_guard
    import nvm_sr_pkg::*;
#(
    parameter int unsigned ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wren_i,
    input  logic              cmd_wrdi_i,
    input  logic              cmd_stat_wr_i,
    input  logic              cmd_arr_wr_i,
    input  logic [SR_W-1:0]   wdata_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wp_pin_i,
    input  logic              busy_i,
    input  logic              arr_done_i,
    output logic [SR_W-1:0]   status_o,
    output logic              stat_wr_ok_o,
    output logic              arr_wr_ok_o,
    output logic              id_sel_o
);

    sr_state_t st_d, st_q;
    logic      range_hit;
    logic      stat_ok;
    logic      arr_ok;
    logic      cycle_end;
    logic      pair_req;

    nvm_bp_decode #(.ADDR_W(ADDR_W)) i_decode (
        .bp_i   (st_q.bp),
        .addr_i (addr_i),
        .hit_o  (range_hit)
    );

    nvm_wr_gate i_gate (
        .wel_i       (st_q.wel),
        .pen_i       (st_q.pen),
        .isel_i      (st_q.isel),
        .ilck_i      (st_q.ilck),
        .range_hit_i (range_hit),
        .wp_pin_i    (wp_pin_i),
        .busy_i      (busy_i),
        .stat_ok_o   (stat_ok),
        .arr_ok_o    (arr_ok)
    );

    assign cycle_end = st_q.busy_q & ~busy_i;
    assign pair_req  = wdata_i[B_ISEL] & wdata_i[B_ILCK];

    always_comb begin
        st_d        = st_q;
        st_d.busy_q = busy_i;

        // completion of an accepted write drops the latch
        if (cycle_end && st_q.pend) begin
            st_d.wel  = 1'b0;
            st_d.pend = 1'b0;
        end

        if (arr_done_i) begin
            st_d.isel = 1'b0;
        end

        if (!busy_i) begin
            if (cmd_wren_i) begin
                st_d.wel = 1'b1;
            end
            if (cmd_wrdi_i) begin
                st_d.wel = 1'b0;
            end
            if (cmd_stat_wr_i && stat_ok) begin
                st_d.pen  = wdata_i[B_PEN];
                st_d.bp   = prot_sel_e'(wdata_i[B_BPH:B_BPL]);
                st_d.pend = 1'b1;
                if (!pair_req) begin
                    st_d.isel = wdata_i[B_ISEL];
                    st_d.ilck = st_q.ilck | wdata_i[B_ILCK];
                end
            end
            if (cmd_arr_wr_i && arr_ok) begin
                st_d.pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= SR_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        status_o         = '0;
        status_o[B_PEN]  = st_q.pen;
        status_o[B_ISEL] = st_q.isel;
        status_o[B_PAD]  = 1'b0;
        status_o[B_ILCK] = st_q.ilck;
        status_o[B_BPH]  = st_q.bp[1];
        status_o[B_BPL]  = st_q.bp[0];
        status_o[B_WEL]  = st_q.wel;
        status_o[B_RDY]  = busy_i;
    end

    assign stat_wr_ok_o = stat_ok;
    assign arr_wr_ok_o  = arr_ok;
    assign id_sel_o     = st_q.isel;

endmodule

// File: rtl/nvm_status_guard_chk.sv
module nvm_status_guard_chk #(
    parameter int unsigned ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_wren_i,
    input logic              cmd_wrdi_i,
    input logic              cmd_stat_wr_i,
    input logic              cmd_arr_wr_i,
    input logic [7:0]        wdata_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              wp_pin_i,
    input logic              busy_i,
    input logic              arr_done_i,
    input logic [7:0]        status_o,
    input logic              stat_wr_ok_o,
    input logic              arr_wr_ok_o,
    input logic              id_sel_o
);

    always @(posedge clk) begin
        if (rst_n) begin
            AST_PAD_ZERO: assert (status_o[5] == 1'b0); // R1
        end
    end

    AST_RDY_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[0] == busy_i); // R2

    AST_WREN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_i && cmd_wren_i && !cmd_wrdi_i) |=> status_o[1]); // R3

    AST_WRDI_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_i && cmd_wrdi_i) |=> !status_o[1]); // R3

    AST_FULL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[3:2] == 2'b11 && !status_o[6]) |-> !arr_wr_ok_o); // R4

    AST_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !status_o[1] |-> (!stat_wr_ok_o && !arr_wr_ok_o)); // R5

    AST_HW_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[7] && !wp_pin_i) |-> !stat_wr_ok_o); // R6

    AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stat_wr_i && stat_wr_ok_o && wdata_i[6] && wdata_i[4] && !arr_done_i)
        |=> ($stable(status_o[6]) && $stable(status_o[4]))); // R8

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[4] |=> status_o[4]); // R9

    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_done_i && !cmd_stat_wr_i) |=> !id_sel_o); // R10

    AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> ($stable(status_o[7]) && $stable(status_o[4:1]))); // R12

endmodule

bind nvm_status_guard nvm_status_guard_chk #(.ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_nvm_status_guard.sv
`timescale 1ns/1ps
module test_nvm_status_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wren_i = 1'b0, cmd_wrdi_i = 1'b0;
    logic        cmd_stat_wr_i = 1'b0, cmd_arr_wr_i = 1'b0;
    logic [7:0]  wdata_i = '0;
    logic [14:0] addr_i = '0;
    logic        wp_pin_i = 1'b1, busy_i = 1'b0, arr_done_i = 1'b0;
    logic [7:0]  status_o;
    logic        stat_wr_ok_o, arr_wr_ok_o, id_sel_o;

    int n_chk = 0;
    int n_bad = 0;

    // reference state
    logic       m_pen, m_isel, m_ilck, m_wel, m_pend, m_bprev;
    logic [1:0] m_bp;
    int         bcnt;

    always #2.5 clk = ~clk;

    nvm_status_guard i_nvm_status_guard (.*);

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic in_range(logic [1:0] bp, logic [14:0] a);
        case (bp)
            2'b00:   return 1'b0;
            2'b01:   return a >= 15'h6000;
            2'b10:   return a >= 15'h4000;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [7:0] exp_status(logic busy);
        return {m_pen, m_isel, 1'b0, m_ilck, m_bp, m_wel, busy};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        {cmd_wren_i, cmd_wrdi_i, cmd_stat_wr_i, cmd_arr_wr_i, arr_done_i} = '0;
        busy_i = 1'b0;
        {m_pen, m_isel, m_ilck, m_wel, m_pend, m_bprev} = '0;
        m_bp = 2'b00;
        bcnt = 0;
        #1;
        check("R1 reset status", int'(status_o), 0);
        check("R3 reset latch/ok", int'({stat_wr_ok_o, arr_wr_ok_o}), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // cmd: 0 none, 1 wren, 2 wrdi, 3 status write, 4 array write
    task automatic step(int cmd, logic [7:0] d, logic [14:0] a, logic wp, logic done);
        logic eso, eao, hit, acc, fall;
        string atag;
        @(negedge clk);
        cmd_wren_i    = (cmd == 1);
        cmd_wrdi_i    = (cmd == 2);
        cmd_stat_wr_i = (cmd == 3);
        cmd_arr_wr_i  = (cmd == 4);
        wdata_i = d; addr_i = a; wp_pin_i = wp; arr_done_i = done;
        busy_i = (bcnt > 0);
        #1;
        hit = in_range(m_bp, a);
        eso = m_wel & ~busy_i & ~(m_pen & ~wp);
        eao = m_wel & ~busy_i & (m_isel ? ~m_ilck : ~hit);
        atag = m_isel ? "R9 id-page gate" : (hit ? "R4 range block" : "R5 open range");
        check("R7 status byte", int'(status_o), int'(exp_status(busy_i)));
        check("R1 pad bit", int'(status_o[5]), 0);
        check("R2 busy bit", int'(status_o[0]), int'(busy_i));
        check("R6 status gate", int'(stat_wr_ok_o), int'(eso));
        check(atag, int'(arr_wr_ok_o), int'(eao));
        check("R10 id select", int'(id_sel_o), int'(m_isel));
        // reference update for the coming edge
        fall = m_bprev & ~busy_i;
        acc = 1'b0;
        if (fall && m_pend) begin m_wel = 1'b0; m_pend = 1'b0; end
        if (done) m_isel = 1'b0;
        if (!busy_i) begin
            if (cmd == 1) m_wel = 1'b1;
            if (cmd == 2) m_wel = 1'b0;
            if (cmd == 3 && eso) begin
                m_pen = d[7]; m_bp = d[3:2]; m_pend = 1'b1; acc = 1'b1;
                if (!(d[6] && d[4])) begin m_isel = d[6]; m_ilck = m_ilck | d[4]; end
            end
            if (cmd == 4 && eao) begin m_pend = 1'b1; acc = 1'b1; end
        end
        m_bprev = busy_i;
        if (bcnt > 0) bcnt--;
        else if (acc) bcnt = 2 + int'($urandom % 4);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 8'h00, 15'h0, 1'b1, 1'b0);
    endtask

    task automatic after_edge();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        do_reset();

        // R8: select and lock together are refused, other fields load
        step(1, 8'h00, 15'h0, 1'b1, 1'b0);
        step(3, 8'h5C, 15'h0, 1'b1, 1'b0);
        after_edge();
        check("R8 pair select", int'(status_o[6]), 0);
        check("R8 pair lock", int'(status_o[4]), 0);
        check("R8 bp loaded", int'(status_o[3:2]), 3);
        // R12: write-disable during busy is ignored
        step(2, 8'h00, 15'h0, 1'b1, 1'b0);
        after_edge();
        check("R12 latch kept in busy", int'(status_o[1]), 1);
        idle(8);
        check("R11 latch cleared at end", int'(status_o[1]), 0);

        // R6/R4: hardware lock and full-array protection
        step(1, 8'h00, 15'h0, 1'b1, 1'b0);
        step(3, 8'h8C, 15'h0, 1'b1, 1'b0);
        idle(8);
        step(1, 8'h00, 15'h0, 1'b0, 1'b0);
        step(3, 8'h00, 15'h0, 1'b0, 1'b0);
        after_edge();
        check("R6 locked status kept", int'(status_o[7]), 1);
        step(4, 8'h00, 15'h0000, 1'b1, 1'b0);
        step(3, 8'h04, 15'h0, 1'b1, 1'b0);
        idle(8);
        step(1, 8'h00, 15'h0, 1'b1, 1'b0);
        step(4, 8'h00, 15'h5FFF, 1'b0, 1'b0);
        idle(8);

        // R9/R10: identification page select, use, auto clear, then lock
        step(1, 8'h00, 15'h0, 1'b1, 1'b0);
        step(3, 8'h4C, 15'h0, 1'b1, 1'b0);
        idle(8);
        step(1, 8'h00, 15'h0, 1'b1, 1'b0);
        step(4, 8'h00, 15'h7FFF, 1'b1, 1'b0);
        idle(7);
        step(0, 8'h00, 15'h0, 1'b1, 1'b1);
        after_edge();
        check("R10 select cleared by done", int'(id_sel_o), 0);
        step(1, 8'h00, 15'h0, 1'b1, 1'b0);
        step(3, 8'h10, 15'h0, 1'b1, 1'b0);
        idle(8);
        step(1, 8'h00, 15'h0, 1'b1, 1'b0);
        step(3, 8'h40, 15'h0, 1'b1, 1'b0);
        idle(8);
        step(1, 8'h00, 15'h0, 1'b1, 1'b0);
        step(4, 8'h00, 15'h0100, 1'b1, 1'b0);
        after_edge();
        check("R9 lock sticky", int'(status_o[4]), 1);
        idle(2);

        // constrained random blocks, each from reset
        for (int blk = 0; blk < 4; blk++) begin
            do_reset();
            for (int i = 0; i < 800; i++) begin
                int r;
                int c;
                logic [7:0] d;
                logic dn;
                r = int'($urandom % 10);
                c = (r < 3) ? 1 : (r == 3) ? 2 : (r < 6) ? 3 : (r < 8) ? 4 : 0;
                d = 8'($urandom);
                d[4] = ($urandom % 8 == 0);
                dn = (c == 0) && ($urandom % 6 == 0);
                step(c, d, 15'($urandom), 1'($urandom), dn);
            end
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule